// File: doc/BRIEF.md
# Opcode-Prefixed Register Access Front End

This block sits between a byte-level serial slave and the byte-wide register file of an eight-channel converter. The slave reports transaction starts and stops, each received byte, read-byte requests from the host, and the direction of the transaction. Every write transaction opens with a command opcode that picks burst write or burst read. A register address byte follows it. The block turns the bytes that come after into single-cycle read and write strobes for the register file. It advances the register address after every byte so that values split over adjacent registers move in one burst.

A burst write is a single transaction: the write opcode, the address, and then the data bytes. A burst read needs two transactions. The first is a write transaction that carries the read opcode and the start address. The second is a read transaction, and each host byte request in it fetches the next register. Two regions are read-only: the latest-result window and the combined event flag register. Writes to them produce no strobe, and the address still advances. Addresses above the top of the map read as zero and drop writes. The address counter holds at the top address and does not wrap. An unknown opcode makes the block ignore the rest of its transaction.

Top module: `cmd_reg_front`

## Requirements
- R1: After reset, rf_we_o, rf_re_o and tx_valid_o are 0 and rf_addr_o is 0x00.
- R2: In a write transaction that opens with opcode 0x28, the second byte sets the address. Each further byte gives one rf_we_o pulse on the cycle after that byte is accepted. The pulse carries rf_addr_o equal to the current address and rf_wdata_o equal to the byte. rf_we_o and rf_re_o are never high together.
- R3: Successive data bytes in a burst go to successive addresses (address + 1 per byte).
- R4: Address 0x18 and addresses 0xA0 to 0xAF are read-only. A data byte aimed at them produces no rf_we_o, and the address still advances.
- R5: Addresses above 0xAF never produce rf_we_o.
- R6: The address counter stops at 0xAF. Further bytes or reads in a burst stay at 0xAF.
- R7: Opcode 0x30 followed by an address byte arms a burst read and produces no strobes, including for any extra bytes. In a later read transaction, each rd_req_i pulse gives an rf_re_o pulse one cycle later at the current address, which then advances. tx_valid_o pulses two cycles after rd_req_i with tx_data_o equal to the register data.
- R8: A read request at an address above 0xAF produces no rf_re_o, and tx_valid_o returns 0x00.
- R9: A first byte other than 0x28 or 0x30 makes the block ignore the rest of the transaction with no strobes. A read transaction that follows returns 0x00 with no rf_re_o.
- R10: A read transaction not preceded by a read-opcode setup (for example after a 0x28 write) returns 0x00 with no rf_re_o.
- R11: Bytes received after a stop and before the next start produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start pulse |
| stop_i | input | 1 | Transaction stop pulse |
| rnw_i | input | 1 | Direction sampled with start_i: 1 read, 0 write |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Host requests the next read byte |
| rf_rdata_i | input | 8 | Register file read data for rf_addr_o |
| rf_we_o | output | 1 | Register write strobe |
| rf_re_o | output | 1 | Register read strobe (read side effects) |
| rf_addr_o | output | 8 | Register address for the strobe |
| rf_wdata_o | output | 8 | Register write data |
| tx_valid_o | output | 1 | Read byte ready for the slave |
| tx_data_o | output | 8 | Read byte |

## Verification
The hardest situation to reach is a counter that saturates on its way out of a read-only window. It only shows as repeated read strobes at 0xAF. Getting there takes a read setup at 0xAE followed by a separate read transaction of three requests, and every returned byte must match the address pattern the bench drives back. Write strobes near the read-only windows are walked through a table of bursts that straddle 0x18, 0xA0 and 0xB0. Directed sequences then arrange the read phases that must not be armed: after an unknown opcode and after a plain write.

// File: rtl/cmd_reg_front_pkg.sv
`timescale 1ns/1ps
package cmd_reg_front_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RHOLD, ST_SKIP, ST_RPHASE
  } dec_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_kind_e;
endpackage

// File: rtl/cf_decoder.sv
`timescale 1ns/1ps
module cf_decoder
  import cmd_reg_front_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  OPC_RD = 8'h30,
  parameter logic [7:0]  OPC_WR = 8'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rnw_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rd_req_i,
  output logic              ptr_load_o,
  output logic [ADDR_W-1:0] ptr_val_o,
  output logic              wr_fire_o,
  output logic              rd_fire_o,
  output logic              rd_armed_o
);
  dec_state_e state_q;
  op_kind_e   op_q;
  logic       armed_q;
  logic       idle_evt;

  assign idle_evt   = !start_i && !stop_i;
  assign ptr_load_o = idle_evt && rx_valid_i && (state_q == ST_ADDR);
  assign ptr_val_o  = ADDR_W'(rx_data_i);
  assign wr_fire_o  = idle_evt && rx_valid_i && (state_q == ST_WDATA);
  assign rd_fire_o  = idle_evt && rd_req_i && (state_q == ST_RPHASE);
  assign rd_armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      armed_q <= 1'b0;
    end else if (start_i) begin
      state_q <= rnw_i ? ST_RPHASE : ST_OPC;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_OPC: begin
          armed_q <= 1'b0;
          if (rx_data_i[7:0] == OPC_WR) begin
            op_q    <= OP_WR;
            state_q <= ST_ADDR;
          end else if (rx_data_i[7:0] == OPC_RD) begin
            op_q    <= OP_RD;
            state_q <= ST_ADDR;
          end else begin
            op_q    <= OP_NONE;
            state_q <= ST_SKIP;
          end
        end
        ST_ADDR: begin
          if (op_q == OP_WR) begin
            state_q <= ST_WDATA;
          end else begin
            state_q <= ST_RHOLD;
            armed_q <= 1'b1;
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/cf_addr_ptr.sv
`timescale 1ns/1ps
module cf_addr_ptr #(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 8'hAF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ptr_q <= '0;
    else if (load_i)                   ptr_q <= load_val_i;
    else if (adv_i && ptr_q < MAX_ADDR) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/cf_access_guard.sv
`timescale 1ns/1ps
module cf_access_guard #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 8'hAF,
  parameter int NUM_RO = 2,
  parameter logic [NUM_RO*ADDR_W-1:0] RO_LO = {8'hA0, 8'h18},
  parameter logic [NUM_RO*ADDR_W-1:0] RO_HI = {8'hAF, 8'h18}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_range_o,
  output logic              writable_o
);
  logic [NUM_RO-1:0] ro_hit;

  for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
    assign ro_hit[g] = (addr_i >= RO_LO[g*ADDR_W +: ADDR_W]) &&
                       (addr_i <= RO_HI[g*ADDR_W +: ADDR_W]);
  end

  assign in_range_o = (addr_i <= MAX_ADDR);
  assign writable_o = in_range_o && !(|ro_hit);
endmodule

// File: rtl/cf_read_return.sv
`timescale 1ns/1ps
module cf_read_return #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= pend_i;
      if (pend_i) tx_data_o <= re_i ? rdata_i : '0;
    end
  end
endmodule

// File: rtl/cmd_reg_front.sv
`timescale 1ns/1ps
module cmd_reg_front #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 8'hAF,
  parameter logic [7:0] OPC_RD = 8'h30,
  parameter logic [7:0] OPC_WR = 8'h28,
  parameter int NUM_RO = 2,
  parameter logic [NUM_RO*ADDR_W-1:0] RO_LO = {8'hA0, 8'h18},
  parameter logic [NUM_RO*ADDR_W-1:0] RO_HI = {8'hAF, 8'h18}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rnw_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic              rf_re_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic              ptr_load, wr_fire, rd_fire, rd_armed;
  logic [ADDR_W-1:0] ptr_val, ptr;
  logic              in_range, writable;
  logic              rsp_pend_q;

  cf_decoder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPC_RD(OPC_RD), .OPC_WR(OPC_WR)
  ) u_dec (
    .clk_i, .rst_ni, .start_i, .stop_i, .rnw_i, .rx_valid_i, .rx_data_i,
    .rd_req_i,
    .ptr_load_o(ptr_load), .ptr_val_o(ptr_val), .wr_fire_o(wr_fire),
    .rd_fire_o(rd_fire), .rd_armed_o(rd_armed)
  );

  cf_addr_ptr #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) u_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load), .load_val_i(ptr_val),
    .adv_i(wr_fire || rd_fire), .ptr_o(ptr)
  );

  cf_access_guard #(
    .ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR), .NUM_RO(NUM_RO),
    .RO_LO(RO_LO), .RO_HI(RO_HI)
  ) u_guard (
    .addr_i(ptr), .in_range_o(in_range), .writable_o(writable)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_we_o    <= 1'b0;
      rf_re_o    <= 1'b0;
      rf_addr_o  <= '0;
      rf_wdata_o <= '0;
      rsp_pend_q <= 1'b0;
    end else begin
      rf_we_o    <= wr_fire && writable;
      rf_re_o    <= rd_fire && rd_armed && in_range;
      rsp_pend_q <= rd_fire;
      if (wr_fire || rd_fire) rf_addr_o <= ptr;
      if (wr_fire) rf_wdata_o <= rx_data_i;
    end
  end

  cf_read_return #(.DATA_W(DATA_W)) u_ret (
    .clk_i, .rst_ni, .pend_i(rsp_pend_q), .re_i(rf_re_o),
    .rdata_i(rf_rdata_i), .tx_valid_o, .tx_data_o
  );
endmodule

// File: rtl/cmd_reg_front_chk.sv
`timescale 1ns/1ps
module cmd_reg_front_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 8'hAF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rf_we_o,
  input logic              rf_re_o,
  input logic [ADDR_W-1:0] rf_addr_o,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_data_o
);
  a_r2_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && rf_re_o));

  a_r3_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && $past(rf_we_o) |-> rf_addr_o == ADDR_W'($past(rf_addr_o) + 1'b1));

  a_r4_no_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !(rf_addr_o == 8'h18 || (rf_addr_o >= 8'hA0 && rf_addr_o <= 8'hAF)));

  a_r5_we_in_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_addr_o <= MAX_ADDR);

  a_r7_re_then_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_re_o |=> tx_valid_o);

  a_r8_re_in_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_re_o |-> rf_addr_o <= MAX_ADDR);

  a_r8_zero_no_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !$past(rf_re_o) |-> tx_data_o == '0);
endmodule

bind cmd_reg_front cmd_reg_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ADDR(MAX_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rf_we_o(rf_we_o), .rf_re_o(rf_re_o),
  .rf_addr_o(rf_addr_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o)
);

// File: tb/cmd_reg_front_test.sv
`timescale 1ns/1ps
module cmd_reg_front_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, rnw = 1'b0;
  logic       rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] rdata;
  logic       we, re, txv;
  logic [7:0] addr, wdata, txd;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign rdata = addr ^ 8'h5A;

  cmd_reg_front uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .rnw_i(rnw),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rd_req_i(rd_req),
    .rf_rdata_i(rdata), .rf_we_o(we), .rf_re_o(re), .rf_addr_o(addr),
    .rf_wdata_o(wdata), .tx_valid_o(txv), .tx_data_o(txd)
  );

  // {opcode, address, data0, data1, expect_we0, expect_we1}
  localparam logic [33:0] VEC [8] = '{
    {8'h28, 8'h10, 8'h11, 8'h22, 1'b1, 1'b1},
    {8'h28, 8'h17, 8'h33, 8'h44, 1'b1, 1'b0},
    {8'h28, 8'h9F, 8'h55, 8'h66, 1'b1, 1'b0},
    {8'h28, 8'hB0, 8'h77, 8'h88, 1'b0, 1'b0},
    {8'h28, 8'h00, 8'h01, 8'h02, 1'b1, 1'b1},
    {8'h33, 8'h20, 8'h99, 8'hAA, 1'b0, 1'b0},
    {8'h30, 8'h40, 8'h12, 8'h34, 1'b0, 1'b0},
    {8'h28, 8'h19, 8'hAB, 8'hCD, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic begin_txn(input logic dir);
    @(negedge clk); start = 1'b1; rnw = dir;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic end_txn();
    @(negedge clk); stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
  endtask

  // send a byte; returns strobe state seen one cycle after acceptance
  task automatic send_byte(input logic [7:0] b, output logic s_we,
                           output logic [7:0] s_addr, output logic [7:0] s_wd,
                           output logic s_re);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    s_we = we; s_addr = addr; s_wd = wdata; s_re = re;
    rx_valid = 1'b0;
  endtask

  task automatic read_one(input string req, input logic exp_re,
                          input logic [7:0] exp_addr, input logic [7:0] exp_data);
    @(negedge clk); rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
    check({req, " re"}, re, exp_re);
    if (exp_re) check({req, " addr"}, addr, exp_addr);
    @(posedge clk); #1;
    check({req, " tx_valid"}, txv, 1'b1);
    check({req, " tx_data"}, txd, exp_data);
  endtask

  task automatic setup_read(input logic [7:0] a);
    logic w, r; logic [7:0] ad, wd;
    begin_txn(1'b0);
    send_byte(8'h30, w, ad, wd, r);
    check("R7 no strobe on opcode", {w, r}, 2'b00);
    send_byte(a, w, ad, wd, r);
    check("R7 no strobe on address", {w, r}, 2'b00);
    end_txn();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic w, r; logic [7:0] ad, wd;
    repeat (3) @(posedge clk);
    #1;
    check("R1 we after reset", we, 1'b0);
    check("R1 re after reset", re, 1'b0);
    check("R1 tx_valid after reset", txv, 1'b0);
    check("R1 addr after reset", addr, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R7 R9: table of write-phase bursts
    for (int i = 0; i < 8; i++) begin
      logic [7:0] opc, a0, d0, d1;
      logic e0, e1;
      {opc, a0, d0, d1, e0, e1} = VEC[i];
      begin_txn(1'b0);
      send_byte(opc, w, ad, wd, r);
      check("R2 no strobe on opcode", {w, r}, 2'b00);
      send_byte(a0, w, ad, wd, r);
      check("R2 no strobe on address", {w, r}, 2'b00);
      send_byte(d0, w, ad, wd, r);
      check("R4/R5/R9 we byte0", w, e0);
      check("R2 re low during write", r, 1'b0);
      if (e0) begin
        check("R2 addr byte0", ad, a0);
        check("R2 data byte0", wd, d0);
      end
      send_byte(d1, w, ad, wd, r);
      check("R4/R5/R9 we byte1", w, e1);
      if (e1) begin
        check("R3 addr byte1", ad, a0 + 8'h01);
        check("R3 data byte1", wd, d1);
      end
      end_txn();
    end

    // R7: armed read burst from 0x10
    setup_read(8'h10);
    begin_txn(1'b1);
    read_one("R7 read 0x10", 1'b1, 8'h10, 8'h10 ^ 8'h5A);
    read_one("R7 read 0x11", 1'b1, 8'h11, 8'h11 ^ 8'h5A);
    read_one("R7 read 0x12", 1'b1, 8'h12, 8'h12 ^ 8'h5A);
    end_txn();

    // R6: saturation at top address
    setup_read(8'hAE);
    begin_txn(1'b1);
    read_one("R6 read 0xAE", 1'b1, 8'hAE, 8'hAE ^ 8'h5A);
    read_one("R6 read 0xAF", 1'b1, 8'hAF, 8'hAF ^ 8'h5A);
    read_one("R6 hold 0xAF", 1'b1, 8'hAF, 8'hAF ^ 8'h5A);
    end_txn();

    // R8: beyond the map
    setup_read(8'hB5);
    begin_txn(1'b1);
    read_one("R8 read 0xB5", 1'b0, 8'h00, 8'h00);
    read_one("R8 read 0xB6", 1'b0, 8'h00, 8'h00);
    end_txn();

    // R9: unknown opcode disarms read
    begin_txn(1'b0);
    send_byte(8'h44, w, ad, wd, r);
    send_byte(8'h10, w, ad, wd, r);
    check("R9 no strobe after bad opcode", {w, r}, 2'b00);
    end_txn();
    begin_txn(1'b1);
    read_one("R9 read after bad opcode", 1'b0, 8'h00, 8'h00);
    end_txn();

    // R10: read phase after a plain write
    begin_txn(1'b0);
    send_byte(8'h28, w, ad, wd, r);
    send_byte(8'h20, w, ad, wd, r);
    send_byte(8'h01, w, ad, wd, r);
    check("R10 write before read", w, 1'b1);
    end_txn();
    begin_txn(1'b1);
    read_one("R10 unarmed read", 1'b0, 8'h00, 8'h00);
    end_txn();

    // R11: bytes between stop and start
    send_byte(8'h28, w, ad, wd, r);
    check("R11 stray byte 0", {w, r}, 2'b00);
    send_byte(8'h05, w, ad, wd, r);
    check("R11 stray byte 1", {w, r}, 2'b00);
    send_byte(8'h66, w, ad, wd, r);
    check("R11 stray byte 2", {w, r}, 2'b00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule